// File: doc/BRIEF.md
# Byte/Word ALU With Status Flags

This block computes add, add-with-carry, subtract, subtract-with-borrow, compare and the three bitwise operations AND, OR and XOR. It works on either 8-bit or 16-bit operands. The result is combinational, so it is valid in the same cycle as the operands. A 16-bit flag register sits beside the arithmetic. When the caller asserts `exec`, the register captures six status conditions derived from that operation.

Three control bits (direction, interrupt enable, single-step trap) live in the same register. Only the dedicated control write port changes them. The carry stored in the register feeds the next add-with-carry or subtract-with-borrow, so multi-word arithmetic can be chained one operation per cycle.

Top module: `flag_alu`

## Requirements
- R1: After reset every bit of `flags` is 0.
- R2: Op 0 (add) gives A+B and op 1 (add-with-carry) gives A+B+CF. Bit 0 (CF) is set on a carry out of the top bit of the active width.
- R3: Op 2 (subtract) gives A-B and op 3 (subtract-with-borrow) gives A-B-CF. CF is set on a borrow. Op 4 (compare) sets the flags exactly as subtract would, but `result` returns operand A and the difference is not output.
- R4: Op 5 gives AND, op 6 gives OR and op 7 gives XOR. After any of these, CF (bit 0), AF (bit 4) and OF (bit 11) are 0.
- R5: Bit 4 (AF) holds the carry out of bit 3 for additions, or the borrow into bit 3 for subtractions and compare.
- R6: Bit 2 (PF) is 1 when the low 8 bits of the operation's value have an even number of ones, in both widths.
- R7: Bit 6 (ZF) is 1 when the value is zero within the active width. Bit 7 (SF) copies the top bit of the active width.
- R8: Bit 11 (OF) is 1 when the signed result of an add or subtract does not fit the active width.
- R9: With `wide`=0, only bits 7:0 are used: CF, SF, ZF and OF come from them, and `result[15:8]` is 0.
- R10: A `ctl_we` pulse loads `ctl_wdata` bits 10 (direction), 9 (interrupt enable) and 8 (trap) into the same flag bits on the next edge. Nothing else changes those bits.
- R11: Flag bits 15:12, 5, 3 and 1 always read 0, whatever is written to them.
- R12: The status bits 0, 2, 4, 6, 7 and 11 change only on an edge where `exec` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 3 | Operation code (see R2 to R4) |
| wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| a | input | 16 | Operand A |
| b | input | 16 | Operand B |
| exec | input | 1 | Load the status flags from this operation |
| ctl_we | input | 1 | Load the control flags from `ctl_wdata` |
| ctl_wdata | input | 16 | Flag word written by `ctl_we`; only control bits are taken |
| result | output | 16 | Combinational operation result |
| flags | output | 16 | Registered flag word |

## Verification
The assertions check four things on every cycle:
- status bits hold when `exec` is low;
- control bits follow `ctl_wdata` only after `ctl_we`;
- the bitwise operations always clear carry and overflow;
- the stored parity matches the result that was on the port.

Only the bench's scenarios can show that the arithmetic is correct for particular operands: signed overflow at both widths, borrow propagation through subtract-with-borrow, and the carry chain from a byte add into a following word add-with-carry. The same holds for the rule that reserved bits ignore an all-ones write.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int FW = 16;

  // flag bit positions; consumers decode these
  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_TF = 8;
  localparam int FB_IF = 9;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_CMP = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } stat_t;

  function automatic logic even_ones(input logic [7:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flags_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         wide,
  input  logic         cin,
  output logic [W-1:0] res,
  output stat_t        st
);
  localparam int NW = 4;
  localparam int UW = W - BW;

  logic          is_sub, is_logic, cx;
  logic [W-1:0]  bx, logic_r, calc_r;
  logic [W:0]    sum_w;
  logic [BW:0]   sum_b;
  logic [NW:0]   sum_n;
  logic          co_raw, msb_a, msb_b, msb_r;
  // named internal events
  logic          carry_evt, aux_evt, ovf_evt;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    // subtraction as A + ~B + ~borrow_in
    cx       = (((op == OP_ADC) || (op == OP_SBB)) ? cin : 1'b0) ^ is_sub;
    bx       = is_sub ? ~b : b;
    sum_w    = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
    sum_b    = {1'b0, a[BW-1:0]} + {1'b0, bx[BW-1:0]} + {{BW{1'b0}}, cx};
    sum_n    = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cx};

    case (op)
      OP_AND:  logic_r = a & b;
      OP_OR:   logic_r = a | b;
      default: logic_r = a ^ b;
    endcase

    if (wide) begin
      co_raw = sum_w[W];
      msb_a  = a[W-1];
      msb_b  = bx[W-1];
      msb_r  = sum_w[W-1];
      calc_r = is_logic ? logic_r : sum_w[W-1:0];
    end else begin
      co_raw = sum_b[BW];
      msb_a  = a[BW-1];
      msb_b  = bx[BW-1];
      msb_r  = sum_b[BW-1];
      calc_r = {{UW{1'b0}}, (is_logic ? logic_r[BW-1:0] : sum_b[BW-1:0])};
    end

    carry_evt = !is_logic && (co_raw ^ is_sub);
    aux_evt   = !is_logic && (sum_n[NW] ^ is_sub);
    // carry into msb differs from carry out of msb
    ovf_evt   = !is_logic && ((msb_r ^ msb_a ^ msb_b) ^ co_raw);

    st.cf = carry_evt;
    st.af = aux_evt;
    st.of = ovf_evt;
    st.zf = (calc_r == '0);
    st.sf = wide ? calc_r[W-1] : calc_r[BW-1];
    st.pf = even_ones(calc_r[7:0]);

    if (op == OP_CMP) res = wide ? a : {{UW{1'b0}}, a[BW-1:0]};
    else              res = calc_r;
  end

  always_comb begin
    if (!wide) AST_BYTE_UPPER: assert (res[W-1:BW] == '0); // R9
  end
endmodule

// File: rtl/flag_file.sv
module flag_file
  import alu_flags_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec,
  input  stat_t         st,
  input  logic          ctl_we,
  input  logic [FW-1:0] ctl_wdata,
  output logic [FW-1:0] flags
);
  localparam logic [FW-1:0] CTL_MASK =
    (FW'(1) << FB_DF) | (FW'(1) << FB_IF) | (FW'(1) << FB_TF);
  localparam logic [FW-1:0] STAT_MASK =
    (FW'(1) << FB_CF) | (FW'(1) << FB_PF) | (FW'(1) << FB_AF) |
    (FW'(1) << FB_ZF) | (FW'(1) << FB_SF) | (FW'(1) << FB_OF);
  localparam logic [FW-1:0] LIVE_MASK = CTL_MASK | STAT_MASK;

  logic [FW-1:0] flags_q, nxt;

  always_comb begin
    nxt = flags_q;
    if (exec) begin
      nxt[FB_CF] = st.cf;
      nxt[FB_PF] = st.pf;
      nxt[FB_AF] = st.af;
      nxt[FB_ZF] = st.zf;
      nxt[FB_SF] = st.sf;
      nxt[FB_OF] = st.of;
    end
    if (ctl_we) nxt = (nxt & ~CTL_MASK) | (ctl_wdata & CTL_MASK);
    nxt = nxt & LIVE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= nxt;
  end

  assign flags = flags_q;

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ((flags & STAT_MASK) == ($past(flags) & STAT_MASK))); // R12
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ((flags & CTL_MASK) == ($past(ctl_wdata) & CTL_MASK))); // R10
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ((flags & CTL_MASK) == ($past(flags) & CTL_MASK))); // R10
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_flags_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          exec,
  input  logic          ctl_we,
  input  logic [FW-1:0] ctl_wdata,
  output logic [DW-1:0] result,
  output logic [FW-1:0] flags
);
  alu_op_e op_e;
  stat_t   core_st;
  logic    cf_now;
  logic    is_bitwise;

  assign op_e       = alu_op_e'(op);
  assign cf_now     = flags[FB_CF];
  assign is_bitwise = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);

  alu_core #(.W(DW), .BW(8)) u_core (
    .a    (a),
    .b    (b),
    .op   (op_e),
    .wide (wide),
    .cin  (cf_now),
    .res  (result),
    .st   (core_st)
  );

  flag_file u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec      (exec),
    .st        (core_st),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .flags     (flags)
  );

  AST_LOGIC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && is_bitwise) |=> (!flags[FB_CF] && !flags[FB_OF] && !flags[FB_AF])); // R4
  AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op_e != OP_CMP) |=> (flags[FB_PF] == ~^$past(result[7:0]))); // R6
endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op;
  logic        wide;
  logic [15:0] a, b;
  logic        exec, ctl_we;
  logic [15:0] ctl_wdata;
  logic [15:0] result, flags;

  int checks = 0;
  int errors = 0;
  logic [15:0] mf;  // bench model of the flag word

  always #5 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst_n(rst_n), .op(op), .wide(wide), .a(a), .b(b),
    .exec(exec), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .result(result), .flags(flags)
  );

  // {op, wide, a, b}
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h007F, 16'h0001},
    {3'd0, 1'b1, 16'hFFFF, 16'h0001},
    {3'd1, 1'b1, 16'h1234, 16'h0000},
    {3'd2, 1'b0, 16'h0000, 16'h0001},
    {3'd3, 1'b0, 16'h0010, 16'h0001},
    {3'd4, 1'b1, 16'h5555, 16'h5555},
    {3'd2, 1'b1, 16'h8000, 16'h0001},
    {3'd5, 1'b1, 16'hF0F0, 16'h0FF0},
    {3'd6, 1'b0, 16'hAB00, 16'h0081},
    {3'd7, 1'b1, 16'hA5A5, 16'hA5A5},
    {3'd0, 1'b1, 16'h7FFF, 16'h7FFF},
    {3'd1, 1'b0, 16'h3380, 16'h4480},
    {3'd4, 1'b0, 16'h0001, 16'h0080},
    {3'd3, 1'b1, 16'h0000, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // integer restatement of the requirements
  task automatic model(input int o, input bit w, input logic [15:0] ia, input logic [15:0] ib,
                       input bit cin, output logic [15:0] r_out, output logic [15:0] f_out);
    int full, half, av, bv, ci, s, sa, sb, ss, r;
    bit cf, af, of;
    full = w ? 65536 : 256;
    half = full / 2;
    av = int'(ia) % full;
    bv = int'(ib) % full;
    ci = (o == 1 || o == 3) ? int'(cin) : 0;
    sa = (av >= half) ? av - full : av;
    sb = (bv >= half) ? bv - full : bv;
    cf = 0; af = 0; of = 0;
    if (o <= 1) begin
      s = av + bv + ci; cf = (s >= full);
      af = ((av % 16) + (bv % 16) + ci) > 15;
      ss = sa + sb + ci; of = (ss >= half) || (ss < -half);
      r = s % full;
    end else if (o <= 4) begin
      s = av - bv - ci; cf = (s < 0);
      af = ((av % 16) - (bv % 16) - ci) < 0;
      ss = sa - sb - ci; of = (ss >= half) || (ss < -half);
      r = (s + full) % full;
    end else if (o == 5) r = av & bv;
    else if (o == 6)     r = av | bv;
    else                 r = av ^ bv;
    f_out = mf & 16'h0700;
    f_out[0]  = cf;
    f_out[2]  = ($countones(r & 255) % 2) == 0;
    f_out[4]  = af;
    f_out[6]  = (r == 0);
    f_out[7]  = (r >= half);
    f_out[11] = of;
    r_out = (o == 4) ? 16'(av) : 16'(r);
  endtask

  task automatic run_op(input int o, input bit w, input logic [15:0] ia, input logic [15:0] ib);
    logic [15:0] er, ef;
    string tag;
    tag = (o <= 1) ? "R2" : (o <= 4) ? "R3" : "R4";
    if (!w) tag = {tag, " R9"};
    @(negedge clk);
    op = 3'(o); wide = w; a = ia; b = ib; exec = 1'b1;
    #1;
    model(o, w, ia, ib, mf[0], er, ef);
    check({tag, " result"}, result, er);
    @(negedge clk);
    exec = 1'b0;
    mf = ef;
    check({tag, " flags R5 R6 R7 R8"}, flags, ef);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; op = 3'd0; wide = 1'b1; a = '0; b = '0;
    exec = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; mf = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset flags", flags, 16'h0000);

    for (int i = 0; i < NV; i++)
      run_op(int'(VEC[i][35:33]), VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

    // R9: upper operand bytes ignored in byte mode, carry out of bit 7
    run_op(0, 1'b0, 16'h12FF, 16'h3401);
    check("R9 byte add upper zero", result, 16'h0000);
    check("R9 byte add flags", flags & 16'h08D5, 16'h0055);
    // R2: carry from the byte add feeds a word add-with-carry
    @(negedge clk);
    op = 3'd1; wide = 1'b1; a = 16'h0001; b = 16'h0001;
    #1 check("R2 adc chain", result, 16'h0003);

    // R10 R11: all-ones write lands only in control bits
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 16'hFFFF;
    @(negedge clk);
    ctl_we = 1'b0;
    mf = (mf & 16'h08D5) | 16'h0700;
    check("R10 R11 ctl write", flags, mf);
    check("R11 reserved bits", flags & 16'hF02A, 16'h0000);

    // R12: operands change without exec, flags hold
    op = 3'd2; wide = 1'b1; a = 16'h0000; b = 16'h0001;
    @(negedge clk);
    @(negedge clk);
    check("R12 hold without exec", flags, mf);

    // R10: clearing control bits leaves status untouched
    ctl_we = 1'b1; ctl_wdata = 16'h0000;
    @(negedge clk);
    ctl_we = 1'b0;
    mf = mf & 16'h08D5;
    check("R10 ctl clear", flags, mf);

    // R4: logic op after a carry-producing op clears CF
    run_op(0, 1'b1, 16'hFFFF, 16'hFFFF);
    run_op(5, 1'b0, 16'h00FF, 16'h0000);
    check("R4 cf of af cleared", flags & 16'h0811, 16'h0000);

    // R1: reset again clears control bits too
    ctl_we = 1'b1; ctl_wdata = 16'h0700;
    @(negedge clk);
    ctl_we = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset clears all", flags, 16'h0000);

    finish_run();
  end
endmodule